// File: doc/BRIEF.md
# Two-Channel Dual-Address DMA Engine

This block is a bus-master DMA controller with two channels. Software programs each channel through a small flat register file. Each channel has a source pointer, a destination pointer, a byte count and a control word. When started, a channel asks a shared engine to move operands over a request/grant master bus. An operand is 1, 2, 4 or 16 bytes. A 16-byte operand travels as four 32-bit beats.

There are three transfer modes:
- **Dual-address:** each operand is read from the source pointer into a holding register and then written to the destination pointer.
- **Single-address:** one bus cycle per operand, at the source pointer. The cycle is a read or a write, chosen in the control word. The peripheral on the other side of the bus takes or supplies the data.
- **Burst single-address:** like single-address with 16-byte operands, with a burst flag raised on the bus. It is allowed on channel 0 only.

A peripheral acknowledge strobe marks the cycles that belong to the peripheral side. After each operand the pointers advance and the count drops. The channel then ends with a done status, or with an error status if the bus reported an error or the start request was illegal.

Channel 0 has fixed priority when both channels wait for the bus. Once an operand has started, it always finishes before the bus is arbitrated again.

Top module: `dma2ch_top`

## Requirements
- R1: In dual-address mode each operand is read from the source pointer, then written to the destination pointer. The written data equals the data read at the matching beat.
- R2: Size code 00, 01, 10 and 11 selects 1, 2, 4 and 16 bytes. After each operand the pointers advance by that many bytes. A 16-byte operand is four 32-bit beats at offsets 0, 4, 8 and 12. The source pointer advances after the read phase and the destination pointer after the write phase.
- R3: Each completed operand lowers the byte count by the operand size, saturating at zero.
  - When the count reaches zero without error, the done bit sets and busy clears.
  - A start with a count of zero sets done at once, with no bus cycle.
- R4: Single-address mode (mode 01) performs one bus cycle per operand (four beats for size 11) at the source pointer.
  - Control bit 5 selects the direction: 0 is read, 1 is write.
  - The bus write-data is zero.
  - The destination pointer is not used.
- R5: Burst mode (mode 10) is legal only on channel 0.
  - It forces 16-byte operands and raises bus_burst on every beat.
  - A start with mode 10 on channel 1, or with mode 11 on either channel, is rejected. The rejection sets that channel's error bit, leaves done clear and runs no bus cycle.
- R6: periph_ack is high only during a bus cycle.
  - In dual-address mode it marks the read cycles when control bit 4 is 0, and the write cycles when bit 4 is 1.
  - In the single-address and burst modes it marks every cycle.
- R7: bus_req is raised while the engine has work. No bus cycle (bus_valid) begins before bus_gnt has been seen high.
- R8: A cycle that completes with bus_err high stops the channel. It sets the error bit, leaves done clear, and no further cycle of that channel follows.
- R9: When both channels are waiting at grant, channel 0 goes first. A started operand runs to its end before the other channel gets a cycle. bus_chan names the owner of the current cycle.
- R10: Register map:
  - cfg_addr[2] selects the channel. cfg_addr[1:0] selects 0 source, 1 destination, 2 count (low 16 bits), 3 control.
  - Control word fields: [1:0] mode (00 dual, 01 single, 10 burst), [3:2] size, [4] acknowledge on destination, [5] single-address write, [8] start.
  - A start clears done and error.
  - Writes to a busy channel are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: channel and register |
| cfg_wdata | input | 32 | Register write data |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | A bus cycle is in progress |
| bus_we | output | 1 | 1 for write cycle, 0 for read |
| bus_addr | output | 32 | Cycle byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_size | output | 2 | Operand size code |
| bus_burst | output | 1 | Beat belongs to a burst single-address operand |
| bus_chan | output | 1 | Channel owning the cycle |
| bus_ready | input | 1 | Cycle completes this clock |
| bus_err | input | 1 | Completing cycle ended in error |
| periph_ack | output | 1 | Peripheral acknowledge strobe |
| ch_busy | output | 2 | Per-channel busy |
| ch_done | output | 2 | Per-channel done status |
| ch_err | output | 2 | Per-channel error status |

## Verification
A wrong pointer or beat counter shows on bus_addr in the very next bus cycle, since every address is the pointer plus a beat offset. A stale or mis-latched holding register shows as wrong bus_wdata on the following write beat. A count that is off shows as too few or too many operands at the bus. The wrong ending appears on ch_done or ch_err within a clock of the last completed cycle. A faulty arbiter or operand lock shows as the wrong bus_chan at the first beat after a grant.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int CW    = 16;
  localparam int NBEAT = 4;

  typedef enum logic [1:0] {
    MODE_DUAL   = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_BURST  = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic [1:0] size;
    logic       ack_dst;
    logic       single_wr;
  } chcfg_t;

  function automatic logic [4:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   step_bytes = 5'd1;
      2'b01:   step_bytes = 5'd2;
      2'b10:   step_bytes = 5'd4;
      default: step_bytes = 5'd16;
    endcase
  endfunction

  function automatic logic [1:0] last_beat(input logic [1:0] sz);
    last_beat = (sz == 2'b11) ? 2'(NBEAT - 1) : 2'd0;
  endfunction
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter bit BURST_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          src_step,
  input  logic          cnt_step,
  input  logic          op_err,
  output chcfg_t        cfg_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  chcfg_t        cfg_q, cfg_n;
  logic [AW-1:0] src_q, src_n, dst_q, dst_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n, done_q, done_n, err_q, err_n;
  logic          en;
  mode_e         wmode;
  logic [CW-1:0] step_c;

  assign wmode  = mode_e'(wr_data[1:0]);
  assign step_c = CW'(step_bytes(cfg_q.size));
  assign en     = wr_en | src_step | cnt_step | op_err;

  always_comb begin
    cfg_n  = cfg_q;
    src_n  = src_q;
    dst_n  = dst_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = done_q;
    err_n  = err_q;
    if (!busy_q) begin
      if (wr_en) begin
        case (wr_sel)
          2'd0: src_n = wr_data;
          2'd1: dst_n = wr_data;
          2'd2: cnt_n = wr_data[CW-1:0];
          default: begin
            cfg_n.mode      = wmode;
            cfg_n.size      = (wmode == MODE_BURST) ? 2'b11 : wr_data[3:2];
            cfg_n.ack_dst   = wr_data[4];
            cfg_n.single_wr = wr_data[5];
            if (wr_data[8]) begin
              done_n = 1'b0;
              err_n  = 1'b0;
              if (wmode == MODE_RSVD || (wmode == MODE_BURST && !BURST_OK))
                err_n = 1'b1;
              else if (cnt_q == '0)
                done_n = 1'b1;
              else
                busy_n = 1'b1;
            end
          end
        endcase
      end
    end else begin
      if (src_step) src_n = src_q + AW'(step_c);
      if (cnt_step) begin
        if (cfg_q.mode == MODE_DUAL) dst_n = dst_q + AW'(step_c);
        cnt_n = (cnt_q > step_c) ? (cnt_q - step_c) : '0;
        if (cnt_n == '0) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end
      end
      if (op_err) begin
        busy_n = 1'b0;
        err_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (en) begin
      cfg_q  <= cfg_n;
      src_q  <= src_n;
      dst_q  <= dst_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  assign cfg_o  = cfg_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic [CHW-1:0] win
);
  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) win = CHW'(i);
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          busy,
  input  chcfg_t [NCH-1:0]        cfg,
  input  logic [NCH-1:0][AW-1:0]  src,
  input  logic [NCH-1:0][AW-1:0]  dst,
  output logic [NCH-1:0]          src_step,
  output logic [NCH-1:0]          cnt_step,
  output logic [NCH-1:0]          op_err,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic                    bus_valid,
  output logic                    bus_we,
  output logic [AW-1:0]           bus_addr,
  output logic [DW-1:0]           bus_wdata,
  input  logic [DW-1:0]           bus_rdata,
  output logic [1:0]              bus_size,
  output logic                    bus_burst,
  output logic [CHW-1:0]          bus_chan,
  input  logic                    bus_ready,
  input  logic                    bus_err,
  output logic                    periph_ack
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RD, S_WR} state_e;

  state_e                      st_q, st_n;
  logic [CHW-1:0]              ch_q, ch_n, win;
  logic [1:0]                  beat_q, beat_n;
  logic [NBEAT-1:0][DW-1:0]    hold_q, hold_n;
  logic                        hold_en;
  chcfg_t                      cur, wcfg;
  logic                        dual;
  logic [AW-1:0]               base;

  dma_arb #(.NCH(NCH)) u_arb (.req(busy), .win(win));

  assign cur  = cfg[ch_q];
  assign wcfg = cfg[win];
  assign dual = (cur.mode == MODE_DUAL);

  always_comb begin
    st_n     = st_q;
    ch_n     = ch_q;
    beat_n   = beat_q;
    hold_n   = hold_q;
    hold_en  = 1'b0;
    src_step = '0;
    cnt_step = '0;
    op_err   = '0;
    case (st_q)
      S_IDLE: if (|busy) st_n = S_REQ;
      S_REQ: begin
        if (!(|busy)) st_n = S_IDLE;
        else if (bus_gnt) begin
          ch_n   = win;
          beat_n = 2'd0;
          st_n   = (wcfg.mode != MODE_DUAL && wcfg.single_wr) ? S_WR : S_RD;
        end
      end
      S_RD: if (bus_ready) begin
        if (bus_err) begin
          op_err[ch_q] = 1'b1;
          st_n         = S_IDLE;
        end else begin
          hold_en        = 1'b1;
          hold_n[beat_q] = bus_rdata;
          if (beat_q == last_beat(cur.size)) begin
            src_step[ch_q] = 1'b1;
            beat_n         = 2'd0;
            if (dual) st_n = S_WR;
            else begin
              cnt_step[ch_q] = 1'b1;
              st_n           = S_IDLE;
            end
          end else beat_n = beat_q + 2'd1;
        end
      end
      default: if (bus_ready) begin
        if (bus_err) begin
          op_err[ch_q] = 1'b1;
          st_n         = S_IDLE;
        end else if (beat_q == last_beat(cur.size)) begin
          cnt_step[ch_q] = 1'b1;
          if (!dual) src_step[ch_q] = 1'b1;
          st_n = S_IDLE;
        end else beat_n = beat_q + 2'd1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ch_q   <= '0;
      beat_q <= '0;
    end else begin
      st_q   <= st_n;
      ch_q   <= ch_n;
      beat_q <= beat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_n;
  end

  assign base       = (st_q == S_WR && dual) ? dst[ch_q] : src[ch_q];
  assign bus_req    = (st_q != S_IDLE);
  assign bus_valid  = (st_q == S_RD) || (st_q == S_WR);
  assign bus_we     = (st_q == S_WR);
  assign bus_addr   = base + {{(AW-4){1'b0}}, beat_q, 2'b00};
  assign bus_wdata  = (bus_we && dual) ? hold_q[beat_q] : '0;
  assign bus_size   = cur.size;
  assign bus_burst  = bus_valid && (cur.mode == MODE_BURST);
  assign bus_chan   = ch_q;
  assign periph_ack = bus_valid && (!dual || (cur.ack_dst == bus_we));
endmodule

// File: rtl/dma2ch_top.sv
module dma2ch_top
  import dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        bus_req,
  input  logic        bus_gnt,
  output logic        bus_valid,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  output logic [1:0]  bus_size,
  output logic        bus_burst,
  output logic        bus_chan,
  input  logic        bus_ready,
  input  logic        bus_err,
  output logic        periph_ack,
  output logic [1:0]  ch_busy,
  output logic [1:0]  ch_done,
  output logic [1:0]  ch_err
);
  localparam int NCH = 2;

  logic                   rst_i_n;
  chcfg_t [NCH-1:0]       cfg;
  logic [NCH-1:0][AW-1:0] src, dst;
  logic [NCH-1:0]         src_step, cnt_step, op_err;

  dma_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan #(.BURST_OK(g == 0)) u_chan (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .wr_en    (cfg_we && (cfg_addr[2] == 1'(g))),
      .wr_sel   (cfg_addr[1:0]),
      .wr_data  (cfg_wdata),
      .src_step (src_step[g]),
      .cnt_step (cnt_step[g]),
      .op_err   (op_err[g]),
      .cfg_o    (cfg[g]),
      .src_o    (src[g]),
      .dst_o    (dst[g]),
      .busy_o   (ch_busy[g]),
      .done_o   (ch_done[g]),
      .err_o    (ch_err[g])
    );
  end

  dma_engine #(.NCH(NCH)) u_eng (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .busy       (ch_busy),
    .cfg        (cfg),
    .src        (src),
    .dst        (dst),
    .src_step   (src_step),
    .cnt_step   (cnt_step),
    .op_err     (op_err),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt),
    .bus_valid  (bus_valid),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_size   (bus_size),
    .bus_burst  (bus_burst),
    .bus_chan   (bus_chan),
    .bus_ready  (bus_ready),
    .bus_err    (bus_err),
    .periph_ack (periph_ack)
  );
endmodule

// File: rtl/dma2ch_chk.sv
module dma2ch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_gnt,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic [31:0] bus_addr,
  input logic        bus_burst,
  input logic        bus_chan,
  input logic        periph_ack,
  input logic [1:0]  ch_done,
  input logic [1:0]  ch_err
);
  // R7
  gnt_before_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(bus_gnt));

  // R6
  ack_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |-> bus_valid);

  // R5
  burst_ch0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_burst |-> (bus_valid && !bus_chan));

  // R9
  operand_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && $past(bus_valid) && !$past(bus_ready)) |-> $stable(bus_chan));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> $stable(bus_addr));

  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_done[0] && ch_err[0]) && !(ch_done[1] && ch_err[1]));
endmodule

bind dma2ch_top dma2ch_chk u_chk (.*);

// File: tb/test_dma2ch_top.sv
module test_dma2ch_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        bus_req, bus_gnt, bus_valid, bus_we, bus_burst, bus_chan, periph_ack;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size, ch_busy, ch_done, ch_err;
  logic        bus_ready, bus_err;
  logic        gnt_en;

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic        chk_wd;
    logic [31:0] wd;
    logic        ack;
    logic        burst;
    logic        ch;
    string       rq;
  } exp_t;

  exp_t  q[$];
  int    nchk = 0;
  int    nerr = 0;
  int    cyc_n = 0;
  int    err_at = -1;
  int    wcnt = 0;
  string cur_rq = "R7";

  always #5 clk = ~clk;
  assign bus_gnt = bus_req & gnt_en;

  dma2ch_top i_dma2ch_top (.*);

  function automatic logic [31:0] rd_of(input logic [31:0] a);
    return a ^ 32'hC3C3_3C3C;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [71:0] act, input logic [71:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  // bus slave and monitor: one wait state per beat, compares at completion
  always @(negedge clk) begin
    if (!rst_n || !bus_valid) begin
      bus_ready = 1'b0; bus_err = 1'b0; wcnt = 0;
    end else if (wcnt < 1) begin
      bus_ready = 1'b0; bus_err = 1'b0; wcnt++;
    end else begin
      wcnt = 0;
      bus_ready = 1'b1;
      bus_rdata = rd_of(bus_addr);
      bus_err = (cyc_n == err_at);
      cyc_n++;
      if (q.size() == 0) begin
        chk(1'b0, cur_rq, {4'h0, bus_addr, bus_wdata, 4'h0}, 72'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(bus_addr == e.addr && bus_we == e.we && periph_ack == e.ack &&
            bus_burst == e.burst && bus_chan == e.ch && (!e.chk_wd || bus_wdata == e.wd),
            e.rq,
            {bus_we, periph_ack, bus_burst, bus_chan, bus_addr, bus_wdata, 4'h0},
            {e.we, e.ack, e.burst, e.ch, e.addr, (e.chk_wd ? e.wd : bus_wdata), 4'h0});
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input logic ch, input logic [1:0] mode, input logic [1:0] sz,
                      input logic ackd, input logic swr, input logic [31:0] s,
                      input logic [31:0] d, input logic [15:0] cnt);
    wr({ch, 2'd0}, s);
    wr({ch, 2'd1}, d);
    wr({ch, 2'd2}, {16'h0, cnt});
    wr({ch, 2'd3}, {23'd0, 1'b1, 2'b00, swr, ackd, sz, mode});
  endtask

  task automatic exp_run(input logic ch, input logic [1:0] mode, input logic [1:0] sz_in,
                         input logic ackd, input logic swr, input logic [31:0] s,
                         input logic [31:0] d, input int cnt, input string rq);
    logic [1:0] sz;
    int step, nb, nops;
    exp_t e;
    sz   = (mode == 2'b10) ? 2'b11 : sz_in;
    step = (sz == 2'b11) ? 16 : (1 << sz);
    nb   = (sz == 2'b11) ? 4 : 1;
    nops = (cnt + step - 1) / step;
    for (int k = 0; k < nops; k++) begin
      if (mode == 2'b00) begin
        for (int b = 0; b < nb; b++) begin
          e.addr = s + k*step + b*4; e.we = 1'b0; e.chk_wd = 1'b0; e.wd = 0;
          e.ack = !ackd; e.burst = 1'b0; e.ch = ch; e.rq = rq;
          q.push_back(e);
        end
        for (int b = 0; b < nb; b++) begin
          e.addr = d + k*step + b*4; e.we = 1'b1; e.chk_wd = 1'b1;
          e.wd = rd_of(s + k*step + b*4); e.ack = ackd; e.burst = 1'b0; e.ch = ch; e.rq = rq;
          q.push_back(e);
        end
      end else begin
        for (int b = 0; b < nb; b++) begin
          e.addr = s + k*step + b*4; e.we = swr; e.chk_wd = 1'b1; e.wd = 0;
          e.ack = 1'b1; e.burst = (mode == 2'b10); e.ch = ch; e.rq = rq;
          q.push_back(e);
        end
      end
    end
  endtask

  task automatic wait_idle(input string rq);
    @(negedge clk);
    while (ch_busy != 2'b00) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, rq, 72'(q.size()), 72'h0);
  endtask

  task automatic chk_stat(input logic ch, input logic dn, input logic er, input string rq);
    chk(ch_done[ch] == dn && ch_err[ch] == er && !ch_busy[ch], rq,
        {69'h0, ch_busy[ch], ch_done[ch], ch_err[ch]}, {69'h0, 1'b0, dn, er});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; gnt_en = 1'b1;
    bus_ready = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7 R3 reset state
    chk(!bus_req && !bus_valid && ch_done == 0 && ch_err == 0 && ch_busy == 0, "R7",
        {66'h0, bus_req, bus_valid, ch_done, ch_err}, 72'h0);

    // R1 R6 R10: dual, 4-byte, ack on source; write to busy channel ignored
    cur_rq = "R10";
    exp_run(1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 32'h1000, 32'h2000, 12, "R1");
    prog(1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 32'h1000, 32'h2000, 16'd12);
    wr(3'd0, 32'hDEAD_0000);
    wait_idle("R1");
    chk_stat(1'b0, 1'b1, 1'b0, "R3");

    // R2 R6: dual, 16-byte on channel 1, ack on destination
    exp_run(1'b1, 2'b00, 2'b11, 1'b1, 1'b0, 32'h3000, 32'h4000, 32, "R2");
    prog(1'b1, 2'b00, 2'b11, 1'b1, 1'b0, 32'h3000, 32'h4000, 16'd32);
    wait_idle("R2");
    chk_stat(1'b1, 1'b1, 1'b0, "R2");

    // R2: 1-byte and 2-byte steps
    exp_run(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 32'h5001, 32'h6003, 3, "R2");
    prog(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 32'h5001, 32'h6003, 16'd3);
    wait_idle("R2");
    exp_run(1'b0, 2'b00, 2'b01, 1'b1, 1'b0, 32'h5100, 32'h6100, 4, "R2");
    prog(1'b0, 2'b00, 2'b01, 1'b1, 1'b0, 32'h5100, 32'h6100, 16'd4);
    wait_idle("R2");

    // R4: single-address read on channel 1, write on channel 0
    exp_run(1'b1, 2'b01, 2'b01, 1'b0, 1'b0, 32'h7000, 32'h0, 6, "R4");
    prog(1'b1, 2'b01, 2'b01, 1'b0, 1'b0, 32'h7000, 32'h0, 16'd6);
    wait_idle("R4");
    chk_stat(1'b1, 1'b1, 1'b0, "R4");
    exp_run(1'b0, 2'b01, 2'b00, 1'b0, 1'b1, 32'h7100, 32'h0, 3, "R4");
    prog(1'b0, 2'b01, 2'b00, 1'b0, 1'b1, 32'h7100, 32'h0, 16'd3);
    wait_idle("R4");

    // R5: burst on channel 0
    exp_run(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 32'h8000, 32'h0, 32, "R5");
    prog(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 32'h8000, 32'h0, 16'd32);
    wait_idle("R5");
    chk_stat(1'b0, 1'b1, 1'b0, "R5");

    // R5: burst on channel 1 and reserved mode rejected, no bus cycle
    cur_rq = "R5";
    prog(1'b1, 2'b10, 2'b00, 1'b0, 1'b0, 32'h9000, 32'h0, 16'd16);
    wait_idle("R5");
    chk_stat(1'b1, 1'b0, 1'b1, "R5");
    prog(1'b0, 2'b11, 2'b00, 1'b0, 1'b0, 32'h9000, 32'h0, 16'd16);
    wait_idle("R5");
    chk_stat(1'b0, 1'b0, 1'b1, "R5");

    // R3: zero count finishes at once; odd count saturates
    cur_rq = "R3";
    prog(1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 32'hA000, 32'hB000, 16'd0);
    wait_idle("R3");
    chk_stat(1'b0, 1'b1, 1'b0, "R3");
    exp_run(1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 32'hA100, 32'hB100, 6, "R3");
    prog(1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 32'hA100, 32'hB100, 16'd6);
    wait_idle("R3");
    chk_stat(1'b0, 1'b1, 1'b0, "R3");

    // R8: error on the write of the first operand stops the channel
    cur_rq = "R8";
    err_at = cyc_n + 1;
    exp_run(1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 32'hC000, 32'hD000, 4, "R8");
    prog(1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 32'hC000, 32'hD000, 16'd8);
    wait_idle("R8");
    repeat (10) @(negedge clk);
    chk_stat(1'b0, 1'b0, 1'b1, "R8");
    chk(!bus_req, "R8", {71'h0, bus_req}, 72'h0);
    err_at = -1;

    // R9 R7: both waiting at grant, channel 0 first
    cur_rq = "R9";
    gnt_en = 1'b0;
    exp_run(1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 32'hE000, 32'hF000, 4, "R9");
    exp_run(1'b1, 2'b00, 2'b10, 1'b0, 1'b0, 32'hE100, 32'hF100, 8, "R9");
    prog(1'b1, 2'b00, 2'b10, 1'b0, 1'b0, 32'hE100, 32'hF100, 16'd8);
    prog(1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 32'hE000, 32'hF000, 16'd4);
    repeat (3) @(negedge clk);
    chk(bus_req && !bus_valid, "R7", {70'h0, bus_req, bus_valid}, {70'h0, 2'b10});
    gnt_en = 1'b1;
    wait_idle("R9");
    chk_stat(1'b0, 1'b1, 1'b0, "R9");
    chk_stat(1'b1, 1'b1, 1'b0, "R9");

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule